// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is a 32x32 multiplier with a 64-bit accumulator held as a high word and a low word. One command is issued with a single-cycle start pulse. The command carries a 2-bit operation code, two 32-bit operands and a saturation-mode bit. The operations are a signed multiply, an unsigned multiply, a signed 32-bit multiply-accumulate and a signed 16-bit multiply-accumulate. The product passes through a parameterised pipeline. The accumulator is then written once, and a one-cycle done pulse marks that write.

The two plain multiplies replace the whole accumulator. The two accumulates add to it. Each accumulate width has its own clamp rule, which applies only when saturation mode was set with the command.

A separate clear input zeroes the accumulator at any time. The reset is asynchronous and active low. Inside the block it is released in step with the clock.

Top module: `mac_sat_unit`

## Requirements
- R1: Op code 2'b00 writes the signed 64-bit product of the two operands, and op code 2'b01 writes the unsigned product. In both cases bits 63:32 go to the high word and bits 31:0 go to the low word, whatever the saturation bit.
- R2: Op code 2'b10 adds the signed 64-bit product to the accumulator {high,low}, wrapping modulo 2^64 when the saturation bit is 0.
- R3: Op code 2'b11 sign-extends bits 15:0 of each operand, multiplies them and adds the product to {high,low}, wrapping modulo 2^64 when the saturation bit is 0. Bits 31:16 of the operands have no effect.
- R4: For op code 2'b10 with the saturation bit at 1, the result depends on the sign of the 64-bit sum. A negative sum forces bits 31:16 of the high word to ones. A sum that is not negative clears bits 31:15 of the high word. The low word always holds the sum.
- R5: For op code 2'b11 with the saturation bit at 1, a signed sum below -2^31 gives high=1 and low=0x80000000. A sum above 2^31-1 gives high=1 and low=0x7FFFFFFF. Any other sum is stored unchanged.
- R6: A start pulse is taken only while busy is low. The done pulse is high for exactly one cycle. With the default two product stages, done is first seen high in the fourth cycle after the start edge, and the accumulator already holds the new value in that cycle.
- R7: A start pulse that arrives while busy is high is ignored. No second done pulse appears and the result of the running command is unchanged.
- R8: With clear high at a clock edge, both accumulator words read zero after that edge.
- R9: After reset, busy and done are low and both accumulator words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command pulse, taken when idle |
| op | input | 2 | Operation code (see R1 to R3) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sat_mode | input | 1 | Saturation mode for accumulates |
| clr | input | 1 | Zero the accumulator |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse on accumulator write |
| acc_hi | output | 32 | Accumulator high word |
| acc_lo | output | 32 | Accumulator low word |

## Verification
The assertions check the handshake on every cycle: done lasts one cycle, it only follows a busy phase, busy only rises after a start pulse, and a start pulse during busy does not disturb the step counter. They also check every cycle that the accumulator is zero after a clear, and that after a saturating accumulate the result lies in the range its clamp rule allows. Only the bench scenarios can show the exact arithmetic. That covers the product values for each op code, the wrap-around with saturation off, and the exact clamp values at the 16-bit limits. It also covers the fact that the operand upper halves do not affect the 16-bit accumulate.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_MUL_S  = 2'b00,
    OP_MUL_U  = 2'b01,
    OP_MAC_W  = 2'b10,
    OP_MAC_H  = 2'b11
  } mac_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mac_state_e;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic run,
  output logic commit,
  output logic done
);

  localparam int CNTW = $clog2(STAGES + 1);

  mac_state_e state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;

  assign run    = (state_q == ST_RUN);
  assign accept = start && (state_q == ST_IDLE);
  assign commit = run && (cnt_q == CNTW'(STAGES));
  assign done   = done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (cnt_q == CNTW'(STAGES)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_follows_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(run));

  // R6
  run_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(start));

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !commit && start) |=> (run && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/mac_mult_pipe.sv
module mac_mult_pipe
  import mac_pkg::*;
#(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  mac_op_e         op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [2*W-1:0]  prod
);

  localparam int ACCW = 2 * W;
  localparam int H    = W / 2;

  logic [ACCW-1:0] ext_a, ext_b, prod_c;
  logic [ACCW-1:0] stage_q [STAGES];

  // Operand widening: the low 2W bits of a 2W x 2W product are exact.
  always_comb begin
    case (op)
      OP_MUL_U: begin
        ext_a = {{W{1'b0}}, a};
        ext_b = {{W{1'b0}}, b};
      end
      OP_MAC_H: begin
        ext_a = {{(ACCW-H){a[H-1]}}, a[H-1:0]};
        ext_b = {{(ACCW-H){b[H-1]}}, b[H-1:0]};
      end
      default: begin
        ext_a = {{W{a[W-1]}}, a};
        ext_b = {{W{b[W-1]}}, b};
      end
    endcase
    prod_c = ext_a * ext_b;
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  stage_q[0] <= '0;
          else if (en) stage_q[0] <= prod_c;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  stage_q[g] <= '0;
          else if (en) stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign prod = stage_q[STAGES-1];

endmodule

// File: rtl/mac_acc_update.sv
module mac_acc_update
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  mac_op_e          op,
  input  logic             sat,
  input  logic [2*W-1:0]   acc,
  input  logic [2*W-1:0]   prod,
  output logic [2*W-1:0]   acc_new
);

  localparam int ACCW = 2 * W;
  localparam int H    = W / 2;
  localparam logic [ACCW-1:0] LIM_LO = {{(ACCW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic [ACCW-1:0] LIM_HI = {{(ACCW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [W-1:0]    CLAMP_HI = W'(1);

  logic [ACCW-1:0] sum;
  logic            below, above;

  assign sum   = acc + prod;
  assign below = $signed(sum) < $signed(LIM_LO);
  assign above = $signed(sum) > $signed(LIM_HI);

  always_comb begin
    acc_new = sum;
    case (op)
      OP_MUL_S, OP_MUL_U: acc_new = prod;
      OP_MAC_W: begin
        if (sat) begin
          if (sum[ACCW-1]) acc_new[ACCW-1:ACCW-H]   = '1;
          else             acc_new[ACCW-1:ACCW-H-1] = '0;
        end
      end
      OP_MAC_H: begin
        if (sat && below)      acc_new = {CLAMP_HI, LIM_LO[W-1:0]};
        else if (sat && above) acc_new = {CLAMP_HI, LIM_HI[W-1:0]};
      end
      default: acc_new = sum;
    endcase
  end

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_pkg::*;
#(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic          sat_mode,
  input  logic          clr,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  acc_hi,
  output logic [W-1:0]  acc_lo
);

  localparam int ACCW = 2 * W;
  localparam int H    = W / 2;

  logic rst_meta, rst_sync_n;
  logic accept, run, commit;
  mac_op_e cmd_op;
  logic [W-1:0] cmd_a, cmd_b;
  logic cmd_sat;
  logic [ACCW-1:0] prod, acc_q, acc_d, acc_calc;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  mac_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .accept (accept),
    .run    (run),
    .commit (commit),
    .done   (done)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_op  <= OP_MUL_S;
      cmd_a   <= '0;
      cmd_b   <= '0;
      cmd_sat <= 1'b0;
    end else if (accept) begin
      cmd_op  <= mac_op_e'(op);
      cmd_a   <= opnd_a;
      cmd_b   <= opnd_b;
      cmd_sat <= sat_mode;
    end
  end

  mac_mult_pipe #(.W(W), .STAGES(STAGES)) u_mult (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (run),
    .op    (cmd_op),
    .a     (cmd_a),
    .b     (cmd_b),
    .prod  (prod)
  );

  mac_acc_update #(.W(W)) u_upd (
    .op      (cmd_op),
    .sat     (cmd_sat),
    .acc     (acc_q),
    .prod    (prod),
    .acc_new (acc_calc)
  );

  always_comb begin
    acc_d = acc_q;
    if (clr)         acc_d = '0;
    else if (commit) acc_d = acc_calc;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)        acc_q <= '0;
    else if (clr || commit) acc_q <= acc_d;
  end

  assign busy   = run;
  assign acc_hi = acc_q[ACCW-1:W];
  assign acc_lo = acc_q[W-1:0];

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr |=> (acc_hi == '0 && acc_lo == '0));

  // R4
  wide_clamp_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && cmd_sat && cmd_op == OP_MAC_W) |->
      (acc_hi[W-1:W-H] == '1 || acc_hi[W-1:W-H-1] == '0));

  // R5
  half_clamp_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && cmd_sat && cmd_op == OP_MAC_H) |->
      ((acc_hi == '0 && !acc_lo[W-1]) || (acc_hi == '1 && acc_lo[W-1]) ||
       (acc_hi == W'(1) && (acc_lo == {1'b1, {(W-1){1'b0}}} ||
                            acc_lo == {1'b0, {(W-1){1'b1}}}))));

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr && !commit) |=> $stable(acc_q));

endmodule

// File: tb/sim_mac_sat_unit.sv
module sim_mac_sat_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        sat_mode = 1'b0;
  logic        clr = 1'b0;
  logic        busy, done;
  logic [31:0] acc_hi, acc_lo;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [63:0] ref_acc = '0;

  always #2.5 clk = ~clk;

  mac_sat_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_mode(sat_mode), .clr(clr),
    .busy(busy), .done(done), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                                         input logic s, input logic [63:0] acc);
    longint sa, sb, ssum;
    longint unsigned ua, ub;
    logic [63:0] p, sum;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'd0, a};
    ub = {32'd0, b};
    case (o)
      2'b00: return 64'(sa * sb);
      2'b01: return 64'(ua * ub);
      2'b10: begin
        p = 64'(sa * sb);
        sum = acc + p;
        if (s) begin
          if (sum[63]) sum[63:48] = 16'hffff;
          else         sum[63:47] = '0;
        end
        return sum;
      end
      default: begin
        sa = longint'($signed(a[15:0]));
        sb = longint'($signed(b[15:0]));
        p = 64'(sa * sb);
        sum = acc + p;
        ssum = longint'(sum);
        if (s && ssum < -64'sd2147483648) return {32'd1, 32'h8000_0000};
        if (s && ssum > 64'sd2147483647)  return {32'd1, 32'h7fff_ffff};
        return sum;
      end
    endcase
  endfunction

  // Issue one command; poke=1 sends a second start during busy (R7).
  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic s, input bit poke, input string tag);
    int lat;
    int dones;
    logic [63:0] exp;
    exp = model(o, a, b, s, ref_acc);
    @(negedge clk);
    start = 1'b1; op = o; opnd_a = a; opnd_b = b; sat_mode = s;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    dones = 0;
    while (!done && lat < 40) begin
      if (poke && lat == 1) begin
        start = 1'b1; op = ~o; opnd_a = ~a; opnd_b = 32'h1234; sat_mode = ~s;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    // R6 latency: done first visible 4 negedges after the start edge
    check(done && lat == 4, {tag, " R6 latency"}, 64'(lat), 64'd4);
    check({acc_hi, acc_lo} == exp, tag, {acc_hi, acc_lo}, exp);
    ref_acc = exp;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done) dones++;
    end
    // R6 single pulse, R7 no extra completion
    check(dones == 0, {tag, " R6/R7 extra done"}, 64'(dones), 64'd0);
    check({acc_hi, acc_lo} == exp, {tag, " R7 hold"}, {acc_hi, acc_lo}, exp);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    ref_acc = '0;
    check({acc_hi, acc_lo} == 64'd0, "R8 clear", {acc_hi, acc_lo}, 64'd0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(!busy && !done, "R9 flags", {62'd0, busy, done}, 64'd0);
    check({acc_hi, acc_lo} == 64'd0, "R9 acc", {acc_hi, acc_lo}, 64'd0);

    // R1 directed
    run_op(2'b01, 32'hffff_ffff, 32'hffff_ffff, 1'b1, 1'b0, "R1 umul max");
    check({acc_hi, acc_lo} == 64'hffff_fffe_0000_0001, "R1 umul value", {acc_hi, acc_lo}, 64'hffff_fffe_0000_0001);
    run_op(2'b00, 32'hffff_ffff, 32'hffff_ffff, 1'b0, 1'b0, "R1 smul -1*-1");
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R1 smul min*min");

    // R2 wrap without saturation
    run_op(2'b01, 32'hffff_ffff, 32'hffff_ffff, 1'b0, 1'b0, "R2 setup");
    run_op(2'b10, 32'h7fff_ffff, 32'h7fff_ffff, 1'b0, 1'b0, "R2 mac32 wrap");

    // R4 positive and negative clamps
    run_op(2'b00, 32'h7fff_ffff, 32'h7fff_ffff, 1'b0, 1'b0, "R4 setup pos");
    run_op(2'b10, 32'd1, 32'd1, 1'b1, 1'b0, "R4 mac32 sat pos");
    check({acc_hi, acc_lo} == 64'h0000_7fff_0000_0002, "R4 pos value", {acc_hi, acc_lo}, 64'h0000_7fff_0000_0002);
    run_op(2'b00, 32'h8000_0000, 32'h7fff_ffff, 1'b0, 1'b0, "R4 setup neg");
    run_op(2'b10, 32'd0, 32'd5, 1'b1, 1'b0, "R4 mac32 sat neg");
    check({acc_hi, acc_lo} == 64'hffff_0000_8000_0000, "R4 neg value", {acc_hi, acc_lo}, 64'hffff_0000_8000_0000);

    // R5 16-bit clamps
    do_clear();
    for (int i = 0; i < 3; i++) run_op(2'b11, 32'h0000_7fff, 32'h0000_7fff, 1'b1, 1'b0, "R5 mac16 up");
    check({acc_hi, acc_lo} == {32'd1, 32'h7fff_ffff}, "R5 upper clamp", {acc_hi, acc_lo}, {32'd1, 32'h7fff_ffff});
    do_clear();
    for (int i = 0; i < 3; i++) run_op(2'b11, 32'h0000_8000, 32'h0000_7fff, 1'b1, 1'b0, "R5 mac16 down");
    check({acc_hi, acc_lo} == {32'd1, 32'h8000_0000}, "R5 lower clamp", {acc_hi, acc_lo}, {32'd1, 32'h8000_0000});

    // R3 upper halves ignored, wrap without saturation
    do_clear();
    run_op(2'b11, 32'habcd_0002, 32'h1234_0003, 1'b0, 1'b0, "R3 halves");
    check({acc_hi, acc_lo} == 64'd6, "R3 upper bits ignored", {acc_hi, acc_lo}, 64'd6);
    run_op(2'b01, 32'hffff_ffff, 32'hffff_ffff, 1'b0, 1'b0, "R3 setup");
    run_op(2'b11, 32'h5555_8000, 32'h0000_8000, 1'b0, 1'b0, "R3 mac16 nosat");

    // R7 start during busy
    run_op(2'b10, 32'h0000_0100, 32'h0000_0300, 1'b0, 1'b1, "R7 poke");

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0] ro;
      logic [31:0] ra, rb;
      ro = 2'($urandom);
      ra = $urandom;
      rb = $urandom;
      if (($urandom % 4) == 0) ra = {ra[31], 31'h7fff_ffff};
      run_op(ro, ra, rb, 1'($urandom), 1'(($urandom % 8) == 0), "R1/R2/R3/R4/R5 random");
      if (($urandom % 10) == 0) do_clear();
    end
    finish_run();
  end

endmodule